// File: doc/BRIEF.md
# NAND Controller Register Bank

This block is the software-visible register file of a NAND flash controller. A CPU reaches it over a simple 32-bit register bus: a select, a write enable, four byte-lane strobes, an address, write data and registered read data. It holds the interface configuration (bus width, address length, page size, write protect), the flash timing word, the interrupt mask and the chip-enable mode. Its outputs feed the pin sequencer directly.

The interface configuration and timing registers are guarded. A 16-bit key written to the key register arms a one-shot unlock. Only the next write to a guarded register is accepted, and a guarded write made without a fresh key is dropped without any signal. Ready and ECC conditions coming back from the datapath are visible live in a raw status register. Their rising edges are caught in a sticky interrupt status register, which clears when it is read. That register is ANDed with the mask to drive one level-sensitive interrupt line. Writes to the command and address ports become one-cycle strobes that carry the written byte. The reset opcode also raises a dedicated device-reset strobe.

Register word offsets (byte address): command 0x00, address 0x04, interface configuration 0x08, timing 0x0C, interrupt mask 0x10, interrupt status 0x14, raw status 0x18, key 0x1C, chip-enable control 0x20. Any other offset reads zero and ignores writes.

Top module: `nand_regbank`

## Requirements
- R1: A write of 0xA25E to the key register (0x1C) with byte lanes 0 and 1 both enabled arms the unlock. The next write to the interface configuration register (0x08) or the timing register (0x0C) then takes effect. Accesses to other registers in between leave the unlock armed.
- R2: The unlock is single-shot. Any guarded write disarms it, whether or not it was accepted. A guarded write made while disarmed changes nothing. A key write with another value, or with lane 0 or lane 1 off, disarms.
- R3: Interface configuration bits: bit 0 drives cfg_bus16, bit 1 drives cfg_long_addr, bit 2 drives cfg_large_blk and bit 3 drives cfg_wr_prot. The register reads back in bits 3:0.
- R4: The raw status register (0x18) reports the live inputs. Bit 0 is NAND ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, and bit 6 decoder failure. Bits 5:4 hold the corrected-symbol count minus one while errors are detected, and zero otherwise.
- R5: The interrupt status register (0x14) latches the rising edge of each event, whether or not the event is masked. The layout is shared with the mask: bit 0 write-protect fault, bit 1 ECC ready, bit 2 decode error (errors detected), bit 3 decode failure, bit 4 controller ready, bit 5 NAND ready.
- R6: A read of the interrupt status register returns the latched bits and clears them. An edge that arrives in the same cycle as that read stays latched.
- R7: irq is high exactly when a latched status bit is also set in the mask register (0x10, bits 5:0).
- R8: A write to the command port (0x00) with lane 0 enabled pulses cmd_stb for one cycle, with cmd_byte holding bits 7:0, in the cycle after the write. A byte of 0xFF also pulses dev_reset_stb. The address port (0x04) gives addr_stb and addr_byte in the same way. With lane 0 off, no strobe is produced.
- R9: Chip-enable control (0x20) bit 0 drives ce_normal. After reset, every register reads zero except timing, which reads all ones (0x07FFFFFF). Read data appears on bus_rdata in the cycle after the read access and holds until the next read.
- R10: A timing write changes only the bytes whose lane strobe is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| st_nand_rdy | input | 1 | Flash device ready level |
| st_ctrl_rdy | input | 1 | Controller ready level |
| st_ecc_rdy | input | 1 | ECC result ready level |
| st_err_det | input | 1 | Correctable errors detected |
| st_corr_cnt | input | 3 | Corrected symbols (1 to 4) |
| st_dec_fail | input | 1 | Uncorrectable block |
| st_wp_fault | input | 1 | Write attempted under protection |
| cfg_bus16 | output | 1 | 16-bit flash bus |
| cfg_long_addr | output | 1 | Extra address cycle |
| cfg_large_blk | output | 1 | Large-page device |
| cfg_wr_prot | output | 1 | Write protect |
| cfg_timing | output | TIM_W | Timing word |
| ce_normal | output | 1 | Normal chip-enable mode |
| cmd_stb | output | 1 | Command byte strobe |
| cmd_byte | output | 8 | Command byte |
| addr_stb | output | 1 | Address byte strobe |
| addr_byte | output | 8 | Address byte |
| dev_reset_stb | output | 1 | Device reset command issued |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the defaults: ADDR_W of 6, which covers all nine registers, and a 27-bit timing word. With that timing width the top byte lane is only partly populated, so a lane-masked write shows both full-lane replacement and truncation of the unused high bits. With the default key and reset opcode, the bench can show a near-miss key written with only one lane enabled, and a command byte that is not the reset opcode, so that cmd_stb and dev_reset_stb are seen to separate.

// File: rtl/nand_regbank_pkg.sv
package nand_regbank_pkg;

  // word indices of the register map
  localparam int IDX_CMD = 0;
  localparam int IDX_ADR = 1;
  localparam int IDX_IFC = 2;
  localparam int IDX_TIM = 3;
  localparam int IDX_MSK = 4;
  localparam int IDX_IST = 5;
  localparam int IDX_RAW = 6;
  localparam int IDX_KEY = 7;
  localparam int IDX_CEC = 8;

  // interrupt event bit positions (mask and status share them)
  localparam int IRQ_N        = 6;
  localparam int EV_WP_FAULT  = 0;
  localparam int EV_ECC_RDY   = 1;
  localparam int EV_DEC_ERR   = 2;
  localparam int EV_DEC_FAIL  = 3;
  localparam int EV_CTRL_RDY  = 4;
  localparam int EV_NAND_RDY  = 5;

  localparam int IFC_W = 4;
  localparam int RAW_W = 7;

  typedef enum logic [3:0] {
    SEL_CMD,
    SEL_ADR,
    SEL_IFC,
    SEL_TIM,
    SEL_MSK,
    SEL_IST,
    SEL_RAW,
    SEL_KEY,
    SEL_CEC,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/nrb_bus_decode.sv
module nrb_bus_decode
  import nand_regbank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              acc_wr,
  output logic              acc_rd
);

  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] widx;

  assign widx   = bus_addr[ADDR_W-1:2];
  assign acc_wr = bus_sel & bus_we;
  assign acc_rd = bus_sel & ~bus_we;

  always_comb begin
    sel = SEL_NONE;
    if (widx == IW'(IDX_CMD)) sel = SEL_CMD;
    if (widx == IW'(IDX_ADR)) sel = SEL_ADR;
    if (widx == IW'(IDX_IFC)) sel = SEL_IFC;
    if (widx == IW'(IDX_TIM)) sel = SEL_TIM;
    if (widx == IW'(IDX_MSK)) sel = SEL_MSK;
    if (widx == IW'(IDX_IST)) sel = SEL_IST;
    if (widx == IW'(IDX_RAW)) sel = SEL_RAW;
    if (widx == IW'(IDX_KEY)) sel = SEL_KEY;
    if (widx == IW'(IDX_CEC)) sel = SEL_CEC;
  end

endmodule

// File: rtl/nrb_lock_guard.sv
module nrb_lock_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr,
  input  logic key_ok,
  input  logic prot_wr,
  output logic armed,
  output logic prot_ok
);

  logic armed_q, armed_d, armed_en;

  // a key write sets or clears the flag; any guarded write consumes it
  always_comb begin
    armed_en = key_wr | prot_wr;
    armed_d  = armed_q;
    if (key_wr)       armed_d = key_ok;
    else if (prot_wr) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed   = armed_q;
  assign prot_ok = prot_wr & armed_q;

endmodule

// File: rtl/nrb_irq_ctrl.sv
module nrb_irq_ctrl #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] mask,
  input  logic         rd_clr,
  output logic [N-1:0] stat,
  output logic [N-1:0] rise,
  output logic         irq
);

  logic [N-1:0] prev_q;
  logic [N-1:0] stat_q, stat_d;
  logic         stat_en;

  for (genvar g = 0; g < N; g++) begin : g_ev
    assign rise[g]   = ev[g] & ~prev_q[g];
    // a new edge wins over the read clear
    assign stat_d[g] = (stat_q[g] & ~rd_clr) | rise[g];
  end

  assign stat_en = rd_clr | (|rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & mask);

endmodule

// File: rtl/nand_regbank.sv
module nand_regbank
  import nand_regbank_pkg::*;
#(
  parameter int               ADDR_W       = 6,
  parameter int               TIM_W        = 27,
  parameter logic [TIM_W-1:0] TIM_RST      = {TIM_W{1'b1}},
  parameter logic [15:0]      UNLOCK_KEY   = 16'hA25E,
  parameter logic [7:0]       RESET_OPCODE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              st_nand_rdy,
  input  logic              st_ctrl_rdy,
  input  logic              st_ecc_rdy,
  input  logic              st_err_det,
  input  logic [2:0]        st_corr_cnt,
  input  logic              st_dec_fail,
  input  logic              st_wp_fault,
  output logic              cfg_bus16,
  output logic              cfg_long_addr,
  output logic              cfg_large_blk,
  output logic              cfg_wr_prot,
  output logic [TIM_W-1:0]  cfg_timing,
  output logic              ce_normal,
  output logic              cmd_stb,
  output logic [7:0]        cmd_byte,
  output logic              addr_stb,
  output logic [7:0]        addr_byte,
  output logic              dev_reset_stb,
  output logic              irq
);

  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  // ---------------- decode ----------------
  reg_sel_e sel;
  logic     acc_wr, acc_rd;

  nrb_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .sel     (sel),
    .acc_wr  (acc_wr),
    .acc_rd  (acc_rd)
  );

  // ---------------- unlock ----------------
  logic key_wr, key_ok, prot_wr, armed, prot_ok;

  assign key_wr  = acc_wr && (sel == SEL_KEY);
  assign key_ok  = key_wr && (&bus_be[1:0]) && (bus_wdata[15:0] == UNLOCK_KEY);
  assign prot_wr = acc_wr && ((sel == SEL_IFC) || (sel == SEL_TIM));

  nrb_lock_guard u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_wr (key_wr),
    .key_ok (key_ok),
    .prot_wr(prot_wr),
    .armed  (armed),
    .prot_ok(prot_ok)
  );

  // ---------------- byte-lane mask ----------------
  logic [DW-1:0] wmask;
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign wmask[8*b +: 8] = {8{bus_be[b]}};
  end

  // ---------------- interrupt events ----------------
  logic [IRQ_N-1:0] ev_vec, ist_q, ist_rise, msk_q, msk_d;
  logic             ist_rd, msk_en;

  always_comb begin
    ev_vec              = '0;
    ev_vec[EV_WP_FAULT] = st_wp_fault;
    ev_vec[EV_ECC_RDY]  = st_ecc_rdy;
    ev_vec[EV_DEC_ERR]  = st_err_det;
    ev_vec[EV_DEC_FAIL] = st_dec_fail;
    ev_vec[EV_CTRL_RDY] = st_ctrl_rdy;
    ev_vec[EV_NAND_RDY] = st_nand_rdy;
  end

  assign ist_rd = acc_rd && (sel == SEL_IST);

  nrb_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev_vec),
    .mask  (msk_q),
    .rd_clr(ist_rd),
    .stat  (ist_q),
    .rise  (ist_rise),
    .irq   (irq)
  );

  // ---------------- raw status ----------------
  logic [2:0]       cnt_m1;
  logic [1:0]       cnt_fld;
  logic [RAW_W-1:0] raw_vec;

  always_comb begin
    cnt_m1  = st_corr_cnt - 3'd1;
    cnt_fld = st_err_det ? cnt_m1[1:0] : 2'b00;
    raw_vec = {st_dec_fail, cnt_fld, st_err_det, st_ecc_rdy, st_ctrl_rdy, st_nand_rdy};
  end

  // ---------------- next state ----------------
  logic [IFC_W-1:0] ifc_q, ifc_d;
  logic             ifc_en;
  logic [TIM_W-1:0] tim_q, tim_d;
  logic             tim_en;
  logic             cec_q, cec_d, cec_en;
  logic             cmd_stb_q, cmd_stb_d, rst_stb_q, rst_stb_d;
  logic             adr_stb_q, adr_stb_d;
  logic [7:0]       cmd_byte_q, adr_byte_q;
  logic [DW-1:0]    rdata_q, rdata_d;

  always_comb begin
    ifc_en    = prot_ok && (sel == SEL_IFC) && bus_be[0];
    ifc_d     = bus_wdata[IFC_W-1:0];
    tim_en    = prot_ok && (sel == SEL_TIM);
    tim_d     = (tim_q & ~wmask[TIM_W-1:0]) | (bus_wdata[TIM_W-1:0] & wmask[TIM_W-1:0]);
    msk_en    = acc_wr && (sel == SEL_MSK) && bus_be[0];
    msk_d     = bus_wdata[IRQ_N-1:0];
    cec_en    = acc_wr && (sel == SEL_CEC) && bus_be[0];
    cec_d     = bus_wdata[0];
    cmd_stb_d = acc_wr && (sel == SEL_CMD) && bus_be[0];
    rst_stb_d = cmd_stb_d && (bus_wdata[7:0] == RESET_OPCODE);
    adr_stb_d = acc_wr && (sel == SEL_ADR) && bus_be[0];
  end

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_IFC: rdata_d = DW'(ifc_q);
      SEL_TIM: rdata_d = DW'(tim_q);
      SEL_MSK: rdata_d = DW'(msk_q);
      SEL_IST: rdata_d = DW'(ist_q);
      SEL_RAW: rdata_d = DW'(raw_vec);
      SEL_CEC: rdata_d = DW'(cec_q);
      default: rdata_d = '0;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ifc_q <= '0;
    else if (ifc_en) ifc_q <= ifc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tim_q <= TIM_RST;
    else if (tim_en) tim_q <= tim_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msk_q <= '0;
    else if (msk_en) msk_q <= msk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cec_q <= 1'b0;
    else if (cec_en) cec_q <= cec_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb_q <= 1'b0;
      rst_stb_q <= 1'b0;
      adr_stb_q <= 1'b0;
    end else begin
      cmd_stb_q <= cmd_stb_d;
      rst_stb_q <= rst_stb_d;
      adr_stb_q <= adr_stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmd_byte_q <= '0;
    else if (cmd_stb_d) cmd_byte_q <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         adr_byte_q <= '0;
    else if (adr_stb_d) adr_byte_q <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (acc_rd) rdata_q <= rdata_d;
  end

  // ---------------- outputs ----------------
  assign bus_rdata     = rdata_q;
  assign cfg_bus16     = ifc_q[0];
  assign cfg_long_addr = ifc_q[1];
  assign cfg_large_blk = ifc_q[2];
  assign cfg_wr_prot   = ifc_q[3];
  assign cfg_timing    = tim_q;
  assign ce_normal     = cec_q;
  assign cmd_stb       = cmd_stb_q;
  assign cmd_byte      = cmd_byte_q;
  assign addr_stb      = adr_stb_q;
  assign addr_byte     = adr_byte_q;
  assign dev_reset_stb = rst_stb_q;

endmodule

// File: rtl/nand_regbank_chk.sv
module nand_regbank_chk #(
  parameter int          ADDR_W       = 6,
  parameter int          IRQ_N        = 6,
  parameter logic [7:0]  RESET_OPCODE = 8'hFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [IRQ_N-1:0]  ev_vec,
  input logic [IRQ_N-1:0]  ist_q,
  input logic [IRQ_N-1:0]  msk_q,
  input logic [3:0]        ifc_q,
  input logic              armed,
  input logic              irq,
  input logic              cmd_stb,
  input logic [7:0]        cmd_byte,
  input logic              dev_reset_stb
);

  localparam int IW = ADDR_W - 2;

  logic [IRQ_N-1:0] prev_ev_q;
  logic [IRQ_N-1:0] edges;
  logic             wr_ifc, rd_ist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ev_q <= '0;
    else        prev_ev_q <= ev_vec;
  end

  assign edges  = ev_vec & ~prev_ev_q;
  assign wr_ifc = bus_sel && bus_we && (bus_addr[ADDR_W-1:2] == IW'(2)) && bus_be[0];
  assign rd_ist = bus_sel && !bus_we && (bus_addr[ADDR_W-1:2] == IW'(5));

  // R1
  unlocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ifc && armed) |=> (ifc_q == $past(bus_wdata[3:0])));

  // R2
  locked_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ifc && !armed) |=> $stable(ifc_q));

  // R5
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges != '0) |=> ((ist_q & $past(edges)) == $past(edges)));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ist |=> ((ist_q & ~$past(edges)) == '0));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);

  // R8
  reset_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_stb |-> (cmd_stb && (cmd_byte == RESET_OPCODE)));

endmodule

bind nand_regbank nand_regbank_chk #(
  .ADDR_W      (ADDR_W),
  .IRQ_N       (IRQ_N),
  .RESET_OPCODE(RESET_OPCODE)
) chk_u (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_be       (bus_be),
  .bus_wdata    (bus_wdata),
  .ev_vec       (ev_vec),
  .ist_q        (ist_q),
  .msk_q        (msk_q),
  .ifc_q        (ifc_q),
  .armed        (armed),
  .irq          (irq),
  .cmd_stb      (cmd_stb),
  .cmd_byte     (cmd_byte),
  .dev_reset_stb(dev_reset_stb)
);

// File: tb/nand_regbank_test.sv
module nand_regbank_test;

  localparam int AW    = 6;
  localparam int TW    = 27;
  localparam int NV    = 27;

  typedef struct packed {
    logic        wr;
    logic [3:0]  be;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  rq;
  } vec_t;

  // write rows: register write; read rows: d holds the expected read data
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'hF, 8'h1C, 32'h0000A25E, 4'd1},  // R1 arm
    '{1'b1, 4'hF, 8'h08, 32'h00000006, 4'd1},
    '{1'b0, 4'hF, 8'h08, 32'h00000006, 4'd1},  // R1 R3 accepted
    '{1'b1, 4'hF, 8'h08, 32'h0000000F, 4'd2},  // no key
    '{1'b0, 4'hF, 8'h08, 32'h00000006, 4'd2},  // R2 discarded
    '{1'b1, 4'hF, 8'h1C, 32'h0000A25E, 4'd1},
    '{1'b1, 4'hF, 8'h10, 32'h00000021, 4'd1},  // unrelated write between
    '{1'b1, 4'hF, 8'h0C, 32'h01234567, 4'd1},
    '{1'b0, 4'hF, 8'h0C, 32'h01234567, 4'd1},  // R1 still armed
    '{1'b1, 4'hF, 8'h0C, 32'h00000000, 4'd2},  // key consumed
    '{1'b0, 4'hF, 8'h0C, 32'h01234567, 4'd2},  // R2 single shot
    '{1'b1, 4'hF, 8'h1C, 32'h0000A25E, 4'd2},
    '{1'b1, 4'hF, 8'h1C, 32'h00001234, 4'd2},  // wrong key disarms
    '{1'b1, 4'hF, 8'h08, 32'h00000001, 4'd2},
    '{1'b0, 4'hF, 8'h08, 32'h00000006, 4'd2},  // R2
    '{1'b1, 4'hF, 8'h1C, 32'h0000A25E, 4'd10},
    '{1'b1, 4'h2, 8'h0C, 32'hFFFFFFFF, 4'd10}, // lane 1 only
    '{1'b0, 4'hF, 8'h0C, 32'h0123FF67, 4'd10}, // R10
    '{1'b0, 4'hF, 8'h10, 32'h00000021, 4'd7},  // R7 mask readback
    '{1'b1, 4'hF, 8'h20, 32'h00000001, 4'd9},
    '{1'b0, 4'hF, 8'h20, 32'h00000001, 4'd9},  // R9
    '{1'b1, 4'h3, 8'h1C, 32'h0000A25E, 4'd1},
    '{1'b1, 4'hF, 8'h0C, 32'hFFFFFFFF, 4'd10},
    '{1'b0, 4'hF, 8'h0C, 32'h07FFFFFF, 4'd10}, // R10 truncated to width
    '{1'b1, 4'h1, 8'h1C, 32'h0000A25E, 4'd2},  // one lane: disarm
    '{1'b1, 4'hF, 8'h08, 32'h00000000, 4'd2},
    '{1'b0, 4'hF, 8'h08, 32'h00000006, 4'd2}   // R2
  };

  logic          clk, rst_n;
  logic          bus_sel, bus_we;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          st_nand_rdy, st_ctrl_rdy, st_ecc_rdy, st_err_det, st_dec_fail, st_wp_fault;
  logic [2:0]    st_corr_cnt;
  logic          cfg_bus16, cfg_long_addr, cfg_large_blk, cfg_wr_prot, ce_normal;
  logic [TW-1:0] cfg_timing;
  logic          cmd_stb, addr_stb, dev_reset_stb, irq;
  logic [7:0]    cmd_byte, addr_byte;

  int n_chk;
  int n_fail;
  logic [31:0] rd;

  nand_regbank #(.ADDR_W(AW), .TIM_W(TW)) uut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_nand_rdy(st_nand_rdy), .st_ctrl_rdy(st_ctrl_rdy), .st_ecc_rdy(st_ecc_rdy),
    .st_err_det(st_err_det), .st_corr_cnt(st_corr_cnt), .st_dec_fail(st_dec_fail),
    .st_wp_fault(st_wp_fault),
    .cfg_bus16(cfg_bus16), .cfg_long_addr(cfg_long_addr), .cfg_large_blk(cfg_large_blk),
    .cfg_wr_prot(cfg_wr_prot), .cfg_timing(cfg_timing), .ce_normal(ce_normal),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .addr_stb(addr_stb), .addr_byte(addr_byte),
    .dev_reset_stb(dev_reset_stb), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[AW-1:0]; bus_be = 4'h0;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    st_nand_rdy = 0; st_ctrl_rdy = 0; st_ecc_rdy = 0; st_err_det = 0;
    st_dec_fail = 0; st_wp_fault = 0; st_corr_cnt = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    chk("R9 reset cmd_stb", {31'b0, cmd_stb}, 32'h0);
    chk("R9 reset timing pins", 32'(cfg_timing), 32'h07FFFFFF);
    bus_read(8'h08, rd); chk("R9 reset ifcfg", rd, 32'h0);
    bus_read(8'h0C, rd); chk("R9 reset timing", rd, 32'h07FFFFFF);
    bus_read(8'h10, rd); chk("R9 reset mask", rd, 32'h0);
    bus_read(8'h14, rd); chk("R9 reset status", rd, 32'h0);
    bus_read(8'h20, rd); chk("R9 reset ce", rd, 32'h0);
    @(negedge clk);
    chk("R9 read data holds", bus_rdata, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].a, VECS[i].d, VECS[i].be);
      else begin
        bus_read(VECS[i].a, rd);
        chk($sformatf("R%0d vector %0d", VECS[i].rq, i), rd, VECS[i].d);
      end
    end

    // R3 pins for value 0x6, then 0xB
    chk("R3 pins 6", {28'b0, cfg_wr_prot, cfg_large_blk, cfg_long_addr, cfg_bus16}, 32'h6);
    bus_write(8'h1C, 32'hA25E, 4'hF);
    bus_write(8'h08, 32'hB, 4'hF);
    chk("R3 pins B", {28'b0, cfg_wr_prot, cfg_large_blk, cfg_long_addr, cfg_bus16}, 32'hB);
    chk("R9 ce_normal", {31'b0, ce_normal}, 32'h1);
    chk("R10 timing pins", 32'(cfg_timing), 32'h07FFFFFF);

    // R5 masked-out event still latches; mask is 0x21
    st_ecc_rdy = 1'b1;
    @(negedge clk);
    chk("R7 unmasked event no irq", {31'b0, irq}, 32'h0);
    bus_read(8'h14, rd); chk("R5 ecc edge latched", rd, 32'h02);
    bus_read(8'h14, rd); chk("R6 cleared by read", rd, 32'h0);

    st_nand_rdy = 1'b1;
    @(negedge clk);
    chk("R7 masked event irq", {31'b0, irq}, 32'h1);
    bus_read(8'h14, rd); chk("R5 nand edge latched", rd, 32'h20);
    chk("R7 irq drops after read", {31'b0, irq}, 32'h0);

    // R6 edge in the same cycle as the read survives it
    st_ctrl_rdy = 1'b1;
    bus_read(8'h14, rd); chk("R6 concurrent read value", rd, 32'h0);
    bus_read(8'h14, rd); chk("R6 concurrent edge kept", rd, 32'h10);
    bus_read(8'h14, rd); chk("R5 held level no relatch", rd, 32'h0);

    st_wp_fault = 1'b1;
    @(negedge clk);
    st_wp_fault = 1'b0;
    @(negedge clk);
    chk("R7 wp fault irq", {31'b0, irq}, 32'h1);
    bus_write(8'h10, 32'h0, 4'hF);
    chk("R7 mask cleared irq low", {31'b0, irq}, 32'h0);
    bus_read(8'h14, rd); chk("R5 wp fault latched", rd, 32'h01);

    // R4 raw status
    st_err_det = 1'b1; st_corr_cnt = 3'd3;
    bus_read(8'h18, rd); chk("R4 raw count 3", rd, 32'h2F);
    st_err_det = 1'b0;
    bus_read(8'h18, rd); chk("R4 raw no errors", rd, 32'h07);
    st_dec_fail = 1'b1;
    bus_read(8'h18, rd); chk("R4 raw decoder fail", rd, 32'h47);
    st_err_det = 1'b1; st_corr_cnt = 3'd1;
    bus_read(8'h18, rd); chk("R4 raw count 1", rd, 32'h4F);
    st_corr_cnt = 3'd4;
    bus_read(8'h18, rd); chk("R4 raw count 4", rd, 32'h7F);

    // R8 strobes
    bus_write(8'h00, 32'h80, 4'hF);
    chk("R8 cmd strobe", {31'b0, cmd_stb}, 32'h1);
    chk("R8 cmd byte", {24'b0, cmd_byte}, 32'h80);
    chk("R8 no reset strobe", {31'b0, dev_reset_stb}, 32'h0);
    @(negedge clk);
    chk("R8 strobe one cycle", {31'b0, cmd_stb}, 32'h0);
    bus_write(8'h00, 32'hFF, 4'h1);
    chk("R8 reset strobe", {31'b0, dev_reset_stb}, 32'h1);
    @(negedge clk);
    chk("R8 reset strobe one cycle", {31'b0, dev_reset_stb}, 32'h0);
    bus_write(8'h04, 32'h12, 4'hF);
    chk("R8 addr strobe", {31'b0, addr_stb}, 32'h1);
    chk("R8 addr byte", {24'b0, addr_byte}, 32'h12);
    chk("R8 addr no cmd strobe", {31'b0, cmd_stb}, 32'h0);
    bus_write(8'h00, 32'h30, 4'hE);
    chk("R8 lane0 off no strobe", {31'b0, cmd_stb}, 32'h0);
    chk("R8 lane0 off byte kept", {24'b0, cmd_byte}, 32'hFF);

    finish_run();
  end

endmodule